// File: doc/BRIEF.md
# CAN Error and Overload Frame Sequencer

This block produces the bus-level fields that a CAN node sends once a frame has gone wrong or an overload condition has been raised. After an error is reported it drives the error flag. It then rides out the dominant bits that other nodes' flags superimpose on the bus, sends the delimiter and counts the intermission before the node may transmit again. An overload request produces an overload flag and an overload delimiter in the same way.

The surrounding controller supplies the sampled bus level, a one-cycle strobe at each sample point, single-cycle pulses for a detected error and for an overload request, the node's error-passive status and whether the node is waiting to transmit. The controller uses the frame-end pulse to decide when it may transmit or retransmit. It uses the start-as-identifier pulse to skip its own start-of-frame bit. A fault-injection input lengthens the error flag so that a transmitter's tolerance of long flags can be tested.

Bit levels use 1 for recessive and 0 for dominant. Bit timing, stuffing, CRC and the error counters are outside this block.

Top module: `can_errovl_seq`

## Requirements
- R1: After synchronous reset the block is idle. `tx_bit` is 1 (recessive), `err_active` is 0 and all four pulse outputs are 0.
- R2: An `err_det` pulse from idle makes `tx_bit` 0 from the next cycle while `err_passive` is 0, and `err_active` goes high. `tx_bit` stays 0 for 6 sample points, and `flag_done` pulses after the 6th.
- R3: While `err_passive` is 1, `tx_bit` stays 1 during the error flag and `err_active` is still high.
- R4: After the node's own flag ends, up to 7 dominant samples are tolerated. During them `tx_bit` is 1 and `form_err` does not pulse.
- R5: An 8th consecutive dominant sample after the flag pulses `form_err` and restarts the error flag, so `tx_bit` goes to 0 again for an error-active node.
- R6: The delimiter lasts 8 recessive samples, counted from the first recessive sample after the flag. `err_active` falls after the 8th of them.
- R7: The intermission lasts 3 samples, and `frame_end` pulses after the 3rd. A dominant sample in the 1st or 2nd intermission bit starts an overload flag.
- R8: An `ovl_req` pulse in idle or in the intermission drives 6 dominant flag bits with `err_active` low. These are followed by an 8-bit recessive delimiter and the intermission.
- R9: With `inj_long` at 1, the error flag lasts 11 sample points instead of 6.
- R10: A dominant 3rd intermission sample with `is_tx` at 1 pulses `sof_as_id` together with `frame_end`. With `is_tx` at 0 only `frame_end` pulses.
- R11: A dominant sample during the delimiter pulses `form_err` and restarts the error flag.
- R12: Counters advance only in cycles where `sample_pt` is 1. Clock cycles without a strobe do not shorten the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_pt | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level (1 recessive, 0 dominant) |
| err_det | input | 1 | Pulse: an error was detected |
| ovl_req | input | 1 | Pulse: request an overload frame |
| err_passive | input | 1 | Node is error passive |
| is_tx | input | 1 | Node has a transmission pending |
| inj_long | input | 1 | Fault injection: lengthen the error flag to 11 bits |
| tx_bit | output | 1 | Level driven onto the bus |
| err_active | output | 1 | High during error flag, overlap wait and error delimiter |
| flag_done | output | 1 | Pulse when the node's own flag ends |
| frame_end | output | 1 | Pulse when the intermission completes |
| sof_as_id | output | 1 | Pulse: continue with the identifier, skipping the start bit |
| form_err | output | 1 | Pulse: too many dominant bits after the flag, or dominant in the delimiter |

## Verification
The bit level `tx_bit` and `err_active` change in the first cycle after an `err_det` or `ovl_req` pulse. Every other result changes on the clock edge that takes in a sample strobe. The four pulse outputs are registered, so each one is high only in the cycle after that edge. Each bench task therefore raises the strobe for exactly one cycle and reads every output at the falling edge that closes that cycle. This lets each check be tied to one particular sample point, such as the 6th or 11th flag bit, the 8th overlap bit or the 3rd intermission bit.

// File: rtl/can_errovl_seq.sv
module can_errovl_seq #(
  parameter int FLAG_BITS     = 6,
  parameter int INJ_FLAG_BITS = 11,
  parameter int OVERLAP_MAX   = 7,
  parameter int DELIM_BITS    = 8,
  parameter int IMS_BITS      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_pt,
  input  logic rx_bit,
  input  logic err_det,
  input  logic ovl_req,
  input  logic err_passive,
  input  logic is_tx,
  input  logic inj_long,
  output logic tx_bit,
  output logic err_active,
  output logic flag_done,
  output logic frame_end,
  output logic sof_as_id,
  output logic form_err
);
  localparam int L1   = (INJ_FLAG_BITS > FLAG_BITS) ? INJ_FLAG_BITS : FLAG_BITS;
  localparam int L2   = (DELIM_BITS > OVERLAP_MAX + 1) ? DELIM_BITS : OVERLAP_MAX + 1;
  localparam int LMAX = (L1 > L2) ? L1 : L2;
  localparam int CW   = $clog2(LMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_FLAG, S_WAIT, S_DELIM, S_IMS} st_t;

  st_t st;
  logic ovl;
  logic [CW-1:0] cnt;
  logic [CW-1:0] flag_last;

  assign flag_last  = (inj_long && !ovl) ? CW'(INJ_FLAG_BITS - 1) : CW'(FLAG_BITS - 1);
  assign tx_bit     = !(st == S_FLAG && (ovl || !err_passive));
  assign err_active = !ovl && (st == S_FLAG || st == S_WAIT || st == S_DELIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ovl       <= 1'b0;
      cnt       <= '0;
      flag_done <= 1'b0;
      frame_end <= 1'b0;
      sof_as_id <= 1'b0;
      form_err  <= 1'b0;
    end else begin
      flag_done <= 1'b0;
      frame_end <= 1'b0;
      sof_as_id <= 1'b0;
      form_err  <= 1'b0;
      if (err_det && !(st == S_FLAG && !ovl)) begin
        st  <= S_FLAG;
        ovl <= 1'b0;
        cnt <= '0;
      end else if (ovl_req && (st == S_IDLE || st == S_IMS)) begin
        st  <= S_FLAG;
        ovl <= 1'b1;
        cnt <= '0;
      end else if (sample_pt) begin
        case (st)
          S_FLAG:
            if (cnt == flag_last) begin
              st        <= S_WAIT;
              cnt       <= '0;
              flag_done <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_WAIT:
            if (rx_bit) begin
              st  <= S_DELIM;
              cnt <= CW'(1);
            end else if (cnt == CW'(OVERLAP_MAX)) begin
              st       <= S_FLAG;
              ovl      <= 1'b0;
              cnt      <= '0;
              form_err <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_DELIM:
            if (!rx_bit) begin
              st       <= S_FLAG;
              ovl      <= 1'b0;
              cnt      <= '0;
              form_err <= 1'b1;
            end else if (cnt == CW'(DELIM_BITS - 1)) begin
              st  <= S_IMS;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_IMS:
            if (cnt == CW'(IMS_BITS - 1)) begin
              st        <= S_IDLE;
              ovl       <= 1'b0;
              cnt       <= '0;
              frame_end <= 1'b1;
              sof_as_id <= !rx_bit && is_tx;
            end else if (!rx_bit) begin
              st  <= S_FLAG;
              ovl <= 1'b1;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_errovl_seq_chk.sv
module can_errovl_seq_chk (
  input logic clk,
  input logic rst,
  input logic sample_pt,
  input logic rx_bit,
  input logic err_det,
  input logic ovl_req,
  input logic err_passive,
  input logic is_tx,
  input logic inj_long,
  input logic tx_bit,
  input logic err_active,
  input logic flag_done,
  input logic frame_end,
  input logic sof_as_id,
  input logic form_err
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tx_bit && !err_active && !flag_done && !frame_end && !sof_as_id && !form_err));

  a_r2_flag_level: assert property (@(posedge clk) disable iff (rst)
    $rose(err_active) |-> (tx_bit == err_passive));

  a_r5_restart_flag: assert property (@(posedge clk) disable iff (rst)
    form_err |-> (err_active && tx_bit == err_passive));

  a_r10_sof_third_dom: assert property (@(posedge clk) disable iff (rst)
    sof_as_id |-> (frame_end && !$past(rx_bit) && $past(is_tx)));

  a_r12_pulse_on_sample: assert property (@(posedge clk) disable iff (rst)
    (flag_done || frame_end) |-> $past(sample_pt));

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(sample_pt) && !$past(err_det) && !$past(ovl_req) && !$past(rst) && $stable(err_passive))
      |-> $stable(tx_bit));
endmodule

bind can_errovl_seq can_errovl_seq_chk u_chk (.*);

// File: tb/can_errovl_seq_tb.sv
module can_errovl_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_pt = 1'b0, rx_bit = 1'b1, err_det = 1'b0, ovl_req = 1'b0;
  logic err_passive = 1'b0, is_tx = 1'b0, inj_long = 1'b0;
  logic tx_bit, err_active, flag_done, frame_end, sof_as_id, form_err;
  logic p_fd, p_fe, p_sof, p_fo;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_errovl_seq u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; err_passive = 1'b0; is_tx = 1'b0; inj_long = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    rx_bit = b; sample_pt = 1'b1;
    @(negedge clk);
    sample_pt = 1'b0;
    p_fd = flag_done; p_fe = frame_end; p_sof = sof_as_id; p_fo = form_err;
  endtask

  task automatic pulse_err();
    @(negedge clk); err_det = 1'b1;
    @(negedge clk); err_det = 1'b0;
  endtask

  task automatic pulse_ovl();
    @(negedge clk); ovl_req = 1'b1;
    @(negedge clk); ovl_req = 1'b0;
  endtask

  task automatic to_intermission();
    pulse_ovl();
    for (int i = 0; i < 6; i++) sbit(1'b0);
    for (int i = 0; i < 8; i++) sbit(1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx", tx_bit, 1);
    chk("R1 err_active", err_active, 0);
    chk("R1 pulses", {flag_done, frame_end, sof_as_id, form_err}, 0);
  endtask

  task automatic t_active_frame();
    int early = 0;
    do_reset();
    pulse_err();
    chk("R2 tx after err_det", tx_bit, 0);
    chk("R2 err_active", err_active, 1);
    repeat (20) @(negedge clk);
    chk("R12 no strobe keeps flag", tx_bit, 0);
    for (int i = 0; i < 5; i++) begin sbit(1'b0); early |= p_fd; end
    chk("R2 tx at bit 5", tx_bit, 0);
    chk("R2 no early flag_done", early, 0);
    sbit(1'b0);
    chk("R2 flag_done at bit 6", p_fd, 1);
    chk("R2 tx released", tx_bit, 1);
    early = 0;
    for (int i = 0; i < 3; i++) begin sbit(1'b0); early |= p_fo; end
    chk("R4 overlap no form_err", early, 0);
    chk("R4 tx recessive", tx_bit, 1);
    for (int i = 0; i < 7; i++) sbit(1'b1);
    chk("R6 still active at 7", err_active, 1);
    sbit(1'b1);
    chk("R6 inactive at 8", err_active, 0);
    early = 0;
    for (int i = 0; i < 2; i++) begin sbit(1'b1); early |= p_fe; end
    chk("R7 no early frame_end", early, 0);
    sbit(1'b1);
    chk("R7 frame_end", p_fe, 1);
    chk("R10 no sof on recessive", p_sof, 0);
  endtask

  task automatic t_passive();
    do_reset();
    err_passive = 1'b1;
    pulse_err();
    for (int i = 0; i < 3; i++) sbit(1'b1);
    chk("R3 passive tx", tx_bit, 1);
    chk("R3 passive err_active", err_active, 1);
  endtask

  task automatic t_inject();
    int early = 0;
    do_reset();
    inj_long = 1'b1;
    pulse_err();
    for (int i = 0; i < 10; i++) begin sbit(1'b0); early |= p_fd; end
    chk("R9 tx at bit 10", tx_bit, 0);
    chk("R9 no early flag_done", early, 0);
    sbit(1'b0);
    chk("R9 flag_done at 11", p_fd, 1);
  endtask

  task automatic t_overlap_limit();
    int early = 0;
    do_reset();
    pulse_err();
    for (int i = 0; i < 6; i++) sbit(1'b0);
    for (int i = 0; i < 7; i++) begin sbit(1'b0); early |= p_fo; end
    chk("R4 seven tolerated", early, 0);
    sbit(1'b0);
    chk("R5 form_err at 8", p_fo, 1);
    chk("R5 flag restarted", tx_bit, 0);
  endtask

  task automatic t_overload();
    do_reset();
    pulse_ovl();
    chk("R8 ovl tx", tx_bit, 0);
    chk("R8 ovl not error", err_active, 0);
    for (int i = 0; i < 5; i++) sbit(1'b0);
    chk("R8 ovl tx bit 5", tx_bit, 0);
    sbit(1'b0);
    chk("R8 ovl flag_done", p_fd, 1);
    for (int i = 0; i < 7; i++) sbit(1'b1);
    sbit(1'b1);
    sbit(1'b1);
    sbit(1'b1);
    sbit(1'b1);
    chk("R8 ovl frame_end", p_fe, 1);
  endtask

  task automatic t_third_dom();
    do_reset();
    is_tx = 1'b1;
    to_intermission();
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    chk("R10 sof_as_id tx", p_sof, 1);
    chk("R10 frame_end tx", p_fe, 1);
    chk("R10 tx recessive", tx_bit, 1);
    is_tx = 1'b0;
    to_intermission();
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    chk("R10 rx no sof", p_sof, 0);
    chk("R10 rx frame_end", p_fe, 1);
  endtask

  task automatic t_ims_dom();
    do_reset();
    to_intermission();
    sbit(1'b0);
    chk("R7 overload from ims tx", tx_bit, 0);
    chk("R7 overload not error", err_active, 0);
  endtask

  task automatic t_delim_dom();
    do_reset();
    pulse_err();
    for (int i = 0; i < 6; i++) sbit(1'b0);
    sbit(1'b1);
    sbit(1'b1);
    sbit(1'b0);
    chk("R11 form_err", p_fo, 1);
    chk("R11 flag restarted", tx_bit, 0);
    chk("R11 err_active", err_active, 1);
  endtask

  initial begin
    t_reset();
    t_active_frame();
    t_passive();
    t_inject();
    t_overlap_limit();
    t_overload();
    t_third_dom();
    t_ims_dom();
    t_delim_dom();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule